// File: doc/BRIEF.md
# Dual-Compare Edge-Aligned PWM Timer

This block is a 16-bit up-counting timer that advances on a clock-enable tick supplied by an external prescaler. It holds two configuration registers: a coarse 8-bit register whose value is scaled by 256, and a fine 16-bit register. A role-swap bit decides which of the two sets the length of the period and which sets the high time. In PWM mode the block drives an edge-aligned waveform and asserts its output-enable. In timer mode it counts and pulses the same match flags, but it releases the output.

Register writes are held in shadow copies that load only at a period boundary, or at any time while the timer is stopped. A period therefore never changes length or duty part way through. The two match flags are single-cycle pulses that a host can use as interrupt sources.

Top module: `pwm_dual_timer`

## Requirements
- R1: Mode encoding is `mode`=2'b10 for PWM and 2'b11 for timer. `tmr_oe` is 1 only when `mode`=2'b10 and `out_sel`=2'b10, and `pwm_out` is 0 whenever `tmr_oe` is 0. In timer mode the flags still pulse. Modes 2'b00 and 2'b01 keep the counter at 0, with no flags.
- R2: With `role_swap`=0, the period is `coarse_reg`×256 ticks and the high time is `fine_reg` ticks. For example, a coarse value of 2 and a fine value of 128 give a 512-tick period that is high for 128 ticks (25%).
- R3: With `role_swap`=1, the period is `fine_reg` ticks and the high time is `coarse_reg`×256 ticks. A fine value of 0 as a period means 65536.
- R4: A coarse value of 0 stands for 65536 ticks, both as a period and as a high time.
- R5: When the high time is equal to or greater than the period, `pwm_out` stays 1 for the whole period.
- R6: The output is edge-aligned. It is 1 from count 0 until the count reaches the high-time value, then 0 until the wrap.
- R7: Register writes made during a period take effect only from the next period boundary.
- R8: `period_hit` is a one-cycle pulse in the cycle after the tick that wraps the counter to 0.
- R9: `duty_hit` is a one-cycle pulse in the cycle after the tick that brings the counter to the high-time value. A high time of 0 makes it coincide with `period_hit`.
- R10: With `run_en`=0 the counter is held at 0, `pwm_out` is 0 and neither flag pulses. Re-enabling starts a full period from count 0.
- R11: `clr_sel` has no effect in PWM mode. In timer mode, `clr_sel`=1 uses the selected period and `clr_sel`=0 makes the counter free-run over 65536 ticks.
- R12: The counter advances only on cycles where `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| run_en | input | 1 | Run enable for the counter |
| coarse_we | input | 1 | Write strobe for the coarse register |
| coarse_wdata | input | 8 | Coarse register write data |
| fine_we | input | 1 | Write strobe for the fine register |
| fine_wdata | input | 16 | Fine register write data |
| mode | input | 2 | Operating mode |
| out_sel | input | 2 | Output control field (2'b10 enables the PWM output) |
| role_swap | input | 1 | Swaps the period and duty roles of the two registers |
| clr_sel | input | 1 | Counter clear source in timer mode |
| pwm_out | output | 1 | PWM waveform |
| tmr_oe | output | 1 | Output-enable for the pin |
| period_hit | output | 1 | Period-boundary pulse |
| duty_hit | output | 1 | Duty-match pulse |

## Verification
The period-boundary pulse and the duty-match pulse can fall in the same cycle when the high time latched at the wrap is 0. The bench provokes this by writing 0 to the fine register mid-period. After the next wrap it checks that both flags are high together in the first cycle of the new period, and that the output stays low for the whole period. A behavioural model, built on integer counters, predicts both flags and the output on every cycle. The same cycle-by-cycle comparison covers the case where a register write lands just before a wrap.

// File: rtl/pwm_tmr_pkg.sv
// Package: shared widths and encodings for the dual-compare PWM timer.
// Assumes: the coarse register is narrower than the counter.
package pwm_tmr_pkg;
    localparam int CNT_W_DEF = 16;
    localparam int PER_W_DEF = 8;

    typedef enum logic [1:0] {
        MODE_OFF_A = 2'b00,
        MODE_OFF_B = 2'b01,
        MODE_PWM   = 2'b10,
        MODE_TIMER = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] OUTSEL_PWM = 2'b10;
endpackage

// File: rtl/pwm_cfg_regs.sv
// Module: pwm_cfg_regs
// Holds the coarse and fine registers. Decodes them into candidate period and
// duty values for the next period, according to the role-swap, mode and
// clear-select inputs.
// Assumes: values are VW = CNT_W+1 bits wide, so that 65536 can be represented.
module pwm_cfg_regs #(
    parameter int CNT_W = pwm_tmr_pkg::CNT_W_DEF,
    parameter int PER_W = pwm_tmr_pkg::PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coarse_we,
    input  logic [PER_W-1:0] coarse_wdata,
    input  logic             fine_we,
    input  logic [CNT_W-1:0] fine_wdata,
    input  logic [1:0]       mode,
    input  logic             role_swap,
    input  logic             clr_sel,
    output logic [CNT_W:0]   nxt_period,
    output logic [CNT_W:0]   nxt_duty
);
    import pwm_tmr_pkg::*;

    localparam int VW = CNT_W + 1;
    localparam int SH = CNT_W - PER_W;
    localparam logic [VW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

    logic [PER_W-1:0] coarse_q;
    logic [CNT_W-1:0] fine_q;
    logic [VW-1:0]    coarse_val;
    logic [VW-1:0]    fine_as_per;

    // Register write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else begin
            if (coarse_we) coarse_q <= coarse_wdata;
            if (fine_we)   fine_q   <= fine_wdata;
        end
    end

    // Scale the registers into tick counts; zero stands for the full range.
    always_comb begin
        coarse_val  = (coarse_q == '0) ? FULL : VW'({coarse_q, {SH{1'b0}}});
        fine_as_per = (fine_q == '0) ? FULL : VW'(fine_q);
    end

    // Select the period and duty roles; timer mode may ignore the period.
    always_comb begin
        if (mode == MODE_TIMER && !clr_sel)
            nxt_period = FULL;
        else if (role_swap)
            nxt_period = fine_as_per;
        else
            nxt_period = coarse_val;
        nxt_duty = role_swap ? coarse_val : VW'(fine_q);
    end

    assert_period_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_period != '0);
    assert_period_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_period <= FULL);
endmodule

// File: rtl/pwm_count_core.sv
// Module: pwm_count_core
// The up-counter with its shadow period and duty values, and the two match
// pulses. Shadows follow the candidates while the timer is stopped and load
// them again at each wrap.
// Assumes: nxt_period is never 0.
module pwm_count_core #(
    parameter int CNT_W = pwm_tmr_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic [CNT_W:0]   nxt_period,
    input  logic [CNT_W:0]   nxt_duty,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W:0]   act_duty,
    output logic             period_hit,
    output logic             duty_hit
);
    localparam int VW = CNT_W + 1;
    localparam logic [VW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

    logic [VW-1:0]    act_per;
    logic [CNT_W-1:0] cnt_inc;
    logic             wrap;

    // Next count and the wrap condition.
    always_comb begin
        cnt_inc = cnt + 1'b1;
        wrap    = running && tick && ({1'b0, cnt} == act_per - VW'(1));
    end

    // Counter, shadow registers and match pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            act_per    <= FULL;
            act_duty   <= FULL;
            period_hit <= 1'b0;
            duty_hit   <= 1'b0;
        end else if (!running) begin
            cnt        <= '0;
            act_per    <= nxt_period;
            act_duty   <= nxt_duty;
            period_hit <= 1'b0;
            duty_hit   <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                cnt        <= '0;
                act_per    <= nxt_period;
                act_duty   <= nxt_duty;
                period_hit <= 1'b1;
                duty_hit   <= (nxt_duty == '0);
            end else begin
                cnt        <= cnt_inc;
                period_hit <= 1'b0;
                duty_hit   <= ({1'b0, cnt_inc} == act_duty);
            end
        end else begin
            period_hit <= 1'b0;
            duty_hit   <= 1'b0;
        end
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} < act_per);
    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt == '0 && !period_hit && !duty_hit));
    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_hit |-> cnt == '0);
    assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> ($stable(cnt) && !period_hit && !duty_hit));
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(act_per) && $stable(act_duty)));
    assert_duty_hit_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        duty_hit |-> ({1'b0, cnt} == act_duty));
endmodule

// File: rtl/pwm_out_stage.sv
// Module: pwm_out_stage
// Forms the output-enable from the mode fields and the edge-aligned waveform
// from the count and the shadow duty.
// Assumes: cnt and act_duty come from registers, so the compare is the only
// logic in the path to the output.
module pwm_out_stage #(
    parameter int CNT_W = pwm_tmr_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [1:0]       out_sel,
    input  logic             run_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W:0]   act_duty,
    output logic             pwm_out,
    output logic             tmr_oe
);
    import pwm_tmr_pkg::*;

    // The pin is driven only in PWM mode with the output field set for PWM.
    always_comb begin
        tmr_oe  = (mode == MODE_PWM) && (out_sel == OUTSEL_PWM);
        pwm_out = tmr_oe && run_en && ({1'b0, cnt} < act_duty);
    end

    assert_released_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_oe |-> !pwm_out);
    assert_stopped_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !pwm_out);
    assert_period_start_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out && cnt != '0) |-> act_duty != '0);
endmodule

// File: rtl/pwm_dual_timer.sv
// Module: pwm_dual_timer (top)
// A 16-bit dual-compare timer that produces an edge-aligned PWM output or runs
// as a plain timer with match pulses.
// Assumes: tick is a single-cycle enable synchronous to clk.
module pwm_dual_timer #(
    parameter int CNT_W = pwm_tmr_pkg::CNT_W_DEF,
    parameter int PER_W = pwm_tmr_pkg::PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_en,
    input  logic             coarse_we,
    input  logic [PER_W-1:0] coarse_wdata,
    input  logic             fine_we,
    input  logic [CNT_W-1:0] fine_wdata,
    input  logic [1:0]       mode,
    input  logic [1:0]       out_sel,
    input  logic             role_swap,
    input  logic             clr_sel,
    output logic             pwm_out,
    output logic             tmr_oe,
    output logic             period_hit,
    output logic             duty_hit
);
    logic [CNT_W:0]   nxt_period;
    logic [CNT_W:0]   nxt_duty;
    logic [CNT_W:0]   act_duty;
    logic [CNT_W-1:0] cnt;
    logic             running;

    // The counter runs only in the PWM and timer modes while run_en is set.
    always_comb running = run_en && mode[1];

    pwm_cfg_regs #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .coarse_we(coarse_we), .coarse_wdata(coarse_wdata),
        .fine_we(fine_we), .fine_wdata(fine_wdata),
        .mode(mode), .role_swap(role_swap), .clr_sel(clr_sel),
        .nxt_period(nxt_period), .nxt_duty(nxt_duty)
    );

    pwm_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
        .nxt_period(nxt_period), .nxt_duty(nxt_duty),
        .cnt(cnt), .act_duty(act_duty),
        .period_hit(period_hit), .duty_hit(duty_hit)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .mode(mode), .out_sel(out_sel),
        .run_en(run_en), .cnt(cnt), .act_duty(act_duty),
        .pwm_out(pwm_out), .tmr_oe(tmr_oe)
    );

    assert_flags_need_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (period_hit || duty_hit) |-> $past(running));
endmodule

// File: tb/test_pwm_dual_timer.sv
module test_pwm_dual_timer;
    logic clk = 1'b0;
    logic rst_n, tick, run_en, coarse_we, fine_we, role_swap, clr_sel;
    logic [7:0]  coarse_wdata;
    logic [15:0] fine_wdata;
    logic [1:0]  mode, out_sel;
    logic pwm_out, tmr_oe, period_hit, duty_hit;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int tick_div = 1;
    int div_cnt  = 0;

    // Behavioural reference state.
    longint m_cnt = 0, m_per = 65536, m_duty = 65536, m_coarse = 0, m_fine = 0;
    bit m_ph = 0, m_dh = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_dual_timer i_pwm_dual_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
        .coarse_we(coarse_we), .coarse_wdata(coarse_wdata),
        .fine_we(fine_we), .fine_wdata(fine_wdata),
        .mode(mode), .out_sel(out_sel), .role_swap(role_swap), .clr_sel(clr_sel),
        .pwm_out(pwm_out), .tmr_oe(tmr_oe), .period_hit(period_hit), .duty_hit(duty_hit)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint cand_per();
        if (mode == 2'b11 && !clr_sel) return 65536;
        if (role_swap) return (m_fine == 0) ? 65536 : m_fine;
        return (m_coarse == 0) ? 65536 : m_coarse * 256;
    endfunction

    function automatic longint cand_duty();
        if (role_swap) return (m_coarse == 0) ? 65536 : m_coarse * 256;
        return m_fine;
    endfunction

    // Tick generator: one tick every tick_div cycles.
    always @(posedge clk) begin
        #2;
        if (div_cnt >= tick_div - 1) begin div_cnt = 0; tick = 1'b1; end
        else begin div_cnt++; tick = 1'b0; end
    end

    // Reference model: advance on every clock edge from the inputs held there.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_per = 65536; m_duty = 65536; m_coarse = 0; m_fine = 0;
            m_ph = 0; m_dh = 0;
        end else begin
            longint cp, cd;
            cp = cand_per();
            cd = cand_duty();
            if (!(run_en && mode[1])) begin
                m_cnt = 0; m_per = cp; m_duty = cd; m_ph = 0; m_dh = 0;
            end else if (tick) begin
                if (m_cnt == m_per - 1) begin
                    m_cnt = 0; m_per = cp; m_duty = cd; m_ph = 1; m_dh = (cd == 0);
                end else begin
                    m_cnt++; m_ph = 0; m_dh = (m_cnt == m_duty);
                end
            end else begin
                m_ph = 0; m_dh = 0;
            end
            if (coarse_we) m_coarse = coarse_wdata;
            if (fine_we)   m_fine   = fine_wdata;
        end
    end

    // Compare with the model on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_oe;
            e_oe = (mode == 2'b10) && (out_sel == 2'b10);
            chk("R1", "tmr_oe", tmr_oe, e_oe);
            chk("R6", "pwm_out", pwm_out, e_oe && run_en && (m_cnt < m_duty));
            chk("R8", "period_hit", period_hit, m_ph);
            chk("R9", "duty_hit", duty_hit, m_dh);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr_coarse(input int v);
        step(); coarse_we = 1'b1; coarse_wdata = 8'(v);
        step(); coarse_we = 1'b0;
    endtask

    task automatic wr_fine(input int v);
        step(); fine_we = 1'b1; fine_wdata = 16'(v);
        step(); fine_we = 1'b0;
    endtask

    task automatic wait_ph();
        @(negedge clk);
        while (!period_hit) @(negedge clk);
    endtask

    // Measure one period: from_now=1 counts from the current sample, else from the next.
    task automatic measure(input bit from_now, output int len, output int highs);
        if (!from_now) @(negedge clk);
        len = 0; highs = 0;
        do begin
            len++;
            if (pwm_out) highs++;
            @(negedge clk);
        end while (!period_hit);
    endtask

    task automatic restart();
        step(); run_en = 1'b0;
        step(); run_en = 1'b1;
    endtask

    initial begin
        int len, highs, hits;
        rst_n = 1'b0; tick = 1'b0; run_en = 1'b0; coarse_we = 1'b0; fine_we = 1'b0;
        coarse_wdata = '0; fine_wdata = '0; mode = 2'b00; out_sel = 2'b00;
        role_swap = 1'b0; clr_sel = 1'b0;
        repeat (4) step();
        @(negedge clk);
        chk("R10", "reset pwm_out", pwm_out, 0);
        chk("R10", "reset period_hit", period_hit, 0);
        chk("R1", "reset tmr_oe", tmr_oe, 0);
        step(); rst_n = 1'b1;

        // R2: 512-tick period, 25% duty.
        mode = 2'b10; out_sel = 2'b10;
        wr_coarse(2); wr_fine(128);
        step(); run_en = 1'b1;
        measure(0, len, highs);
        chk("R2", "period length", len, 512);
        chk("R6", "high time", highs, 128);
        chk("R1", "oe in PWM mode", tmr_oe, 1);

        // R7: writes mid-period do not disturb the running period.
        fork
            measure(1, len, highs);
            begin repeat (20) step(); wr_coarse(1); wr_fine(64); end
        join
        chk("R7", "old period kept", len, 512);
        chk("R7", "old high time kept", highs, 128);
        measure(1, len, highs);
        chk("R7", "new period length", len, 256);
        chk("R7", "new high time", highs, 64);

        // R12: tick every fourth cycle.
        tick_div = 4;
        wait_ph();
        measure(1, len, highs);
        chk("R12", "period in cycles", len, 1024);
        chk("R12", "high cycles", highs, 256);
        tick_div = 1;
        wait_ph();

        // R5: duty above period gives 100%.
        wr_fine(300);
        wait_ph();
        measure(1, len, highs);
        chk("R5", "saturated high time", highs, 256);
        chk("R5", "period length", len, 256);

        // R9: zero duty makes both flags coincide.
        wr_fine(0);
        wait_ph();
        chk("R9", "duty_hit with period_hit", duty_hit, 1);
        measure(1, len, highs);
        chk("R9", "zero duty high time", highs, 0);

        // R3: swapped roles.
        role_swap = 1'b1; wr_fine(300); wr_coarse(1);
        wait_ph();
        measure(1, len, highs);
        chk("R3", "swapped period", len, 300);
        chk("R3", "swapped high time", highs, 256);

        // R10: stopped timer is quiet.
        step(); run_en = 1'b0; role_swap = 1'b0;
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_out || period_hit || duty_hit) hits++;
        end
        chk("R10", "activity while stopped", hits, 0);

        // R4: coarse zero means 65536.
        wr_coarse(0); wr_fine(1000);
        step(); run_en = 1'b1;
        measure(0, len, highs);
        chk("R4", "full-range period", len, 65536);
        chk("R10", "restart high time", highs, 1000);

        // R11: clr_sel ignored in PWM mode.
        wr_coarse(1); wr_fine(64); clr_sel = 1'b1;
        restart();
        measure(0, len, highs);
        chk("R11", "PWM period with clr_sel", len, 256);

        // R1: timer mode releases the output, flags still fire.
        mode = 2'b11;
        restart();
        measure(0, len, highs);
        chk("R1", "timer period", len, 256);
        chk("R1", "timer output low", highs, 0);
        chk("R1", "timer oe", tmr_oe, 0);

        // R11: timer mode with clr_sel=0 free-runs.
        step(); clr_sel = 1'b0;
        restart();
        hits = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (period_hit) hits++;
        end
        chk("R11", "no early wrap when free-running", hits, 0);

        // R1: idle mode keeps the counter stopped.
        step(); mode = 2'b01;
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (period_hit || duty_hit || pwm_out) hits++;
        end
        chk("R1", "idle mode activity", hits, 0);

        // R1: PWM mode with the output field not set.
        step(); mode = 2'b10; out_sel = 2'b00;
        @(negedge clk);
        chk("R1", "oe with output field off", tmr_oe, 0);
        repeat (300) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule